// File: doc/BRIEF.md
# Hashed Page Table Group Walker

This block finds the translation for a 4 KiB page by searching a hashed page table held in memory. A request carries a 24-bit segment identifier, a 32-bit effective address, the base address of the table and a mask that sets the table size. The walker hashes the segment identifier with the page index and reads the 64-byte group that the hash selects. It checks that group's eight 8-byte entries in ascending order. If none of them matches, it repeats the scan on the group selected by the complemented hash. It talks to memory through a single port that does 32-bit word reads and single-byte writes, with one request outstanding at a time.

On a hit the walker presents both entry words, the entry's offset within the table, the real address, and whether write permission may be granted. The surrounding permission logic then acknowledges the response and either grants or denies the access. Only after a grant does the walker write back the referenced byte and, for stores, the changed byte of the entry. Each of these is a separate one-byte store. Memory is big-endian: the byte at entry offset +6 holds word-1 bits 15..8, and the byte at +7 holds word-1 bits 7..0. The table base must be 64-byte aligned.

Top module: `hpt_group_walker`

## Requirements
- R1: With page index P = ea[27:12] and hash H = vsid XOR P (24 bits), the first read of a walk is at base + ((H << 6) AND mask).
- R2: Within a group, entries are visited at offsets +0, +8, ... +56 in ascending order, and the first matching entry is returned, even when a later entry also matches.
- R3: The word 0 of an entry (entry offset +0) is read before its word 1 (entry offset +4). Word 1 is read only for an entry whose word 0 matches.
- R4: A word 0 matches when bit 31 (valid) is 1, bit 6 (secondary flag) equals the current pass (0 primary, 1 secondary), and bits 30..7 equal vsid and bits 5..0 equal ea[27:22].
- R5: After eight non-matching primary entries, a second pass reads from base + ((~H << 6) AND mask) and accepts only entries whose secondary flag is 1.
- R6: When both passes miss, the response has rsp_hit = 0, and no word 1 is read and no byte is written.
- R7: On a hit, rsp_word0 and rsp_word1 are the entry words, rsp_offset is the entry offset from the table base, and rsp_raddr is {word1[31:12], ea[11:0]}.
- R8: After a granted hit whose word-1 bit 8 (referenced) is 0, one byte (word1[15:8] OR 0x01) is written at entry offset +6.
- R9: After a granted hit on a store whose word-1 bit 7 (changed) is 0, one byte (word1[7:0] OR 0x80) is written at entry offset +7, after any referenced-byte write.
- R10: rsp_wr_ok is 1 when the access is a store or the changed bit is already 1; otherwise it is 0 (write permission withheld).
- R11: A response acknowledged without grant, and any miss, causes no memory writes.
- R12: req_ready is 1 only while idle. A memory request keeps its address, kind and data stable until acknowledged, and at most one of req_ready, rsp_valid and mem_req is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vsid | input | 24 | Segment identifier |
| req_ea | input | 32 | Effective address |
| req_store | input | 1 | Access is a store |
| tbl_base | input | 32 | Table base address (64-byte aligned) |
| tbl_mask | input | 32 | Table offset mask |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1: byte write, 0: word read |
| mem_addr | output | 32 | Byte address |
| mem_wbyte | output | 8 | Write byte |
| mem_ack | input | 1 | Memory request done |
| mem_rdata | input | 32 | Read word, valid with mem_ack |
| rsp_valid | output | 1 | Result available |
| rsp_hit | output | 1 | Entry found |
| rsp_word0 | output | 32 | Entry word 0 |
| rsp_word1 | output | 32 | Entry word 1 |
| rsp_offset | output | 32 | Entry offset from base |
| rsp_raddr | output | 32 | Real address |
| rsp_wr_ok | output | 1 | Write permission may be given |
| rsp_ack | input | 1 | Result consumed |
| rsp_grant | input | 1 | Access granted, with rsp_ack |

## Verification
The assertions check on every cycle the memory handshake discipline, the single-active-phase rule, the rule that word 1 follows its own word 0 read, that a reported hit carries a valid word 0 with the right secondary flag, and that writes begin only after a granted acknowledge and that the changed byte is written only for stores. The computed hash addresses, first-match priority under duplicate entries, fallback to the complemented group, full misses, the exact written byte values and the withheld write permission can only be shown by the bench's scenarios. Those scenarios build tables with decoy entries and compare the read and write traces against values the bench computes on its own.

// File: rtl/hptw_pkg.sv
package hptw_pkg;
    localparam int ADDR_W     = 32;
    localparam int VSID_W     = 24;
    localparam int PIDX_W     = 16;
    localparam int API_W      = 6;
    localparam int PTE_BYTES  = 8;
    localparam int PTE_SHIFT  = $clog2(PTE_BYTES);
    localparam int W0_VALID   = 31;
    localparam int W0_SEC     = 6;
    localparam int W1_REF     = 8;
    localparam int W1_CHG     = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_RSP,
        ST_WBR,
        ST_WBC
    } walk_st_e;
endpackage

// File: rtl/hptw_hash.sv
module hptw_hash
    import hptw_pkg::*;
#(
    parameter int GRP_SHIFT = 6
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [PIDX_W-1:0] pidx,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] pri_off,
    output logic [ADDR_W-1:0] sec_off,
    output logic [ADDR_W-1:0] tag
);
    localparam int PAD_W = ADDR_W - VSID_W - GRP_SHIFT;

    logic [VSID_W-1:0] hash;

    always_comb begin
        hash    = vsid ^ {{(VSID_W-PIDX_W){1'b0}}, pidx};
        pri_off = {{PAD_W{1'b0}}, hash, {GRP_SHIFT{1'b0}}} & mask;
        sec_off = {{PAD_W{1'b0}}, ~hash, {GRP_SHIFT{1'b0}}} & mask;
        tag     = {1'b0, vsid, 1'b0, pidx[PIDX_W-1 -: API_W]};
    end
endmodule

// File: rtl/hptw_match.sv
module hptw_match
    import hptw_pkg::*;
(
    input  logic [ADDR_W-1:0] word0,
    input  logic [ADDR_W-1:0] tag,
    input  logic              pass,
    output logic              hit
);
    logic [ADDR_W-1:0] cmp_mask;

    always_comb begin
        cmp_mask           = '1;
        cmp_mask[W0_VALID] = 1'b0;
        cmp_mask[W0_SEC]   = 1'b0;
        hit = word0[W0_VALID] && (word0[W0_SEC] == pass)
              && ((word0 & cmp_mask) == tag);
    end
endmodule

// File: rtl/hpt_group_walker.sv
module hpt_group_walker
    import hptw_pkg::*;
#(
    parameter int WAYS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VSID_W-1:0]   req_vsid,
    input  logic [ADDR_W-1:0]   req_ea,
    input  logic                req_store,
    input  logic [ADDR_W-1:0]   tbl_base,
    input  logic [ADDR_W-1:0]   tbl_mask,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_wbyte,
    input  logic                mem_ack,
    input  logic [ADDR_W-1:0]   mem_rdata,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [ADDR_W-1:0]   rsp_word0,
    output logic [ADDR_W-1:0]   rsp_word1,
    output logic [ADDR_W-1:0]   rsp_offset,
    output logic [ADDR_W-1:0]   rsp_raddr,
    output logic                rsp_wr_ok,
    input  logic                rsp_ack,
    input  logic                rsp_grant
);
    localparam int IDX_W     = $clog2(WAYS);
    localparam int GRP_SHIFT = $clog2(WAYS * PTE_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WAYS - 1);

    typedef struct packed {
        walk_st_e          st;
        logic              pass;
        logic [IDX_W-1:0]  idx;
        logic              hit;
        logic              store;
        logic [VSID_W-1:0] vsid;
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] w0;
        logic [ADDR_W-1:0] w1;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [ADDR_W-1:0] pri_off, sec_off, tag, grp_off, ent_off;
    logic              w0_hit;

    hptw_hash #(.GRP_SHIFT(GRP_SHIFT)) u_hash (
        .vsid    (walk_q.vsid),
        .pidx    (walk_q.ea[27:12]),
        .mask    (walk_q.mask),
        .pri_off (pri_off),
        .sec_off (sec_off),
        .tag     (tag)
    );

    hptw_match u_match (
        .word0 (mem_rdata),
        .tag   (tag),
        .pass  (walk_q.pass),
        .hit   (w0_hit)
    );

    always_comb begin
        grp_off = walk_q.pass ? sec_off : pri_off;
        ent_off = grp_off + (ADDR_W'(walk_q.idx) << PTE_SHIFT);
    end

    always_comb begin
        walk_d    = walk_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = walk_q.base + ent_off;
        mem_wbyte = '0;
        case (walk_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.st    = ST_RD0;
                    walk_d.pass  = 1'b0;
                    walk_d.idx   = '0;
                    walk_d.hit   = 1'b0;
                    walk_d.store = req_store;
                    walk_d.vsid  = req_vsid;
                    walk_d.ea    = req_ea;
                    walk_d.base  = tbl_base;
                    walk_d.mask  = tbl_mask;
                end
            end
            ST_RD0: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    walk_d.w0 = mem_rdata;
                    if (w0_hit) begin
                        walk_d.st = ST_RD1;
                    end else if (walk_q.idx != LAST_IDX) begin
                        walk_d.idx = walk_q.idx + 1'b1;
                    end else if (!walk_q.pass) begin
                        walk_d.pass = 1'b1;
                        walk_d.idx  = '0;
                    end else begin
                        walk_d.st = ST_RSP;
                    end
                end
            end
            ST_RD1: begin
                mem_req  = 1'b1;
                mem_addr = walk_q.base + ent_off + ADDR_W'(4);
                if (mem_ack) begin
                    walk_d.w1  = mem_rdata;
                    walk_d.hit = 1'b1;
                    walk_d.st  = ST_RSP;
                end
            end
            ST_RSP: begin
                if (rsp_ack) begin
                    if (walk_q.hit && rsp_grant && !walk_q.w1[W1_REF])
                        walk_d.st = ST_WBR;
                    else if (walk_q.hit && rsp_grant && walk_q.store && !walk_q.w1[W1_CHG])
                        walk_d.st = ST_WBC;
                    else
                        walk_d.st = ST_IDLE;
                end
            end
            ST_WBR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = walk_q.base + ent_off + ADDR_W'(6);
                mem_wbyte = walk_q.w1[15:8] | 8'h01;
                if (mem_ack)
                    walk_d.st = (walk_q.store && !walk_q.w1[W1_CHG]) ? ST_WBC : ST_IDLE;
            end
            ST_WBC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = walk_q.base + ent_off + ADDR_W'(7);
                mem_wbyte = walk_q.w1[7:0] | 8'h80;
                if (mem_ack)
                    walk_d.st = ST_IDLE;
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            walk_q <= '{st: ST_IDLE, default: '0};
        else
            walk_q <= walk_d;
    end

    assign req_ready  = (walk_q.st == ST_IDLE);
    assign rsp_valid  = (walk_q.st == ST_RSP);
    assign rsp_hit    = walk_q.hit;
    assign rsp_word0  = walk_q.w0;
    assign rsp_word1  = walk_q.w1;
    assign rsp_offset = ent_off;
    assign rsp_raddr  = {walk_q.w1[31:12], walk_q.ea[11:0]};
    assign rsp_wr_ok  = walk_q.store || walk_q.w1[W1_CHG];

    // R12: a pending memory request does not change until acknowledged
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wbyte));

    // R12: idle, response and memory phases never overlap
    assert_one_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, rsp_valid, mem_req}));

    // R3: a word-1 read follows the acknowledged word-0 read of that entry
    assert_w1_after_w0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_addr[2] |->
            $past(mem_req && !mem_we && !mem_addr[2] && mem_ack)
            || $past(mem_req && !mem_we && mem_addr[2] && !mem_ack));

    // R4: a reported hit holds a valid word 0 whose flag equals the pass
    assert_hit_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |-> rsp_word0[W0_VALID] && (rsp_word0[W0_SEC] == walk_q.pass));

    // R11: writes start only after a granted acknowledge of a hit
    assert_write_after_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(rsp_valid && rsp_hit && rsp_ack && rsp_grant));

    // R9: the changed byte carries bit 7 set and is written only for stores
    assert_chg_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && (mem_addr[2:0] == 3'd7) |-> walk_q.store && mem_wbyte[7]);
endmodule

// File: tb/hpt_group_walker_test.sv
module hpt_group_walker_test;
    localparam logic [31:0] BASE = 32'h8000_0000;
    localparam logic [31:0] MASK = 32'h0000_0FC0;

    typedef struct packed {
        logic [23:0] vsid;
        logic [31:0] ea;
        logic [1:0]  kind;   // 0 primary hit, 1 secondary hit, 2 miss
        logic [2:0]  idx;
        logic        r;
        logic        c;
        logic        st;
        logic        gr;
    } vec_t;

    localparam vec_t TBL [0:7] = '{
        '{24'h123456, 32'h0ABC_D123, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{24'h00F00F, 32'h3456_7890, 2'd0, 3'd5, 1'b0, 1'b0, 1'b1, 1'b1},
        '{24'hABCDEF, 32'h7FFF_F000, 2'd1, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1},
        '{24'h000001, 32'h1000_0FFF, 2'd1, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1},
        '{24'h555555, 32'hC0DE_0042, 2'd2, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{24'h0FEDCB, 32'h2222_2222, 2'd0, 3'd7, 1'b0, 1'b1, 1'b1, 1'b0},
        '{24'hFFFFFF, 32'hFFFF_FFFF, 2'd0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1},
        '{24'h3C3C3C, 32'h5A5A_5A5A, 2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0;
    logic [23:0] req_vsid = '0;
    logic [31:0] req_ea = '0, tbl_base = BASE, tbl_mask = MASK;
    logic        req_ready, mem_req, mem_we, rsp_valid, rsp_hit, rsp_wr_ok;
    logic [31:0] mem_addr, rsp_word0, rsp_word1, rsp_offset, rsp_raddr;
    logic [7:0]  mem_wbyte;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_ack = 1'b0, rsp_grant = 1'b0;

    always #10 clk = ~clk;

    hpt_group_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vsid(req_vsid), .req_ea(req_ea), .req_store(req_store),
        .tbl_base(tbl_base), .tbl_mask(tbl_mask), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wbyte(mem_wbyte), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_word0(rsp_word0), .rsp_word1(rsp_word1), .rsp_offset(rsp_offset),
        .rsp_raddr(rsp_raddr), .rsp_wr_ok(rsp_wr_ok), .rsp_ack(rsp_ack),
        .rsp_grant(rsp_grant)
    );

    // memory model: table words written by tasks, traces kept by the responder
    logic [31:0] mem [0:1023];
    logic [31:0] rd_log [0:63];
    logic [31:0] wa_log [0:63];
    logic [7:0]  wd_log [0:63];
    int          rd_n = 0, wr_n = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                wa_log[wr_n[5:0]] <= mem_addr;
                wd_log[wr_n[5:0]] <= mem_wbyte;
                wr_n <= wr_n + 1;
            end else begin
                mem_rdata <= mem[(mem_addr - BASE) >> 2];
                rd_log[rd_n[5:0]] <= mem_addr;
                rd_n <= rd_n + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    int checks = 0, fails = 0, cycles = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] tag_of(input logic [23:0] v, input logic [31:0] ea);
        return {1'b0, v, 1'b0, ea[27:22]};
    endfunction

    function automatic logic [31:0] w1_of(input logic [19:0] rpn, input logic r, input logic c);
        return {rpn, 3'b101, r, c, 7'b0110110};
    endfunction

    task automatic put(input logic [31:0] off, input logic [31:0] w0, input logic [31:0] w1);
        mem[off >> 2]       = w0;
        mem[(off >> 2) + 1] = w1;
    endtask

    task automatic run(input vec_t v, input logic [31:0] mask);
        logic [23:0] h;
        logic [31:0] pri, sec, grp, tg, w1, off;
        int rd0, wr0, nw0, nw1, wexp;
        h   = v.vsid ^ {8'h00, v.ea[27:12]};
        pri = {2'b0, h, 6'b0} & mask;
        sec = {2'b0, ~h, 6'b0} & mask;
        tg  = tag_of(v.vsid, v.ea);
        w1  = w1_of(v.vsid[19:0] ^ v.ea[31:12], v.r, v.c);
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        grp = (v.kind == 2'd1) ? sec : pri;
        off = grp + {26'b0, v.idx, 3'b0};
        if (v.kind == 2'd0) begin
            for (int j = 0; j < 8; j++) begin
                if (j < v.idx)
                    put(pri + j*8, (j % 2 == 0) ? tg : (tg | 32'h8000_0040), 32'hDEAD_0000);
                else if (j == v.idx)
                    put(pri + j*8, tg | 32'h8000_0000, w1);
                else if (j == v.idx + 1)
                    put(pri + j*8, tg | 32'h8000_0000, w1 ^ 32'hFFFF_F000);
            end
        end else begin
            for (int j = 0; j < 8; j++) begin
                put(pri + j*8, tg | 32'h8000_0040, 32'hBAD0_0000);
                if (v.kind == 2'd2)
                    put(sec + j*8, tg | 32'h8000_0000, 32'hBAD1_0000);
                else if (j < v.idx)
                    put(sec + j*8, (j % 2 == 0) ? (tg ^ 32'h0000_0080) | 32'h8000_0040
                                                : tg | 32'h8000_0000, 32'hDEAD_0000);
                else if (j == v.idx)
                    put(sec + j*8, tg | 32'h8000_0040, w1);
                else if (j == v.idx + 1)
                    put(sec + j*8, tg | 32'h8000_0040, w1 ^ 32'hFFFF_F000);
            end
        end
        rd0 = rd_n;
        wr0 = wr_n;
        tbl_mask = mask;
        @(negedge clk);
        req_valid = 1'b1; req_vsid = v.vsid; req_ea = v.ea; req_store = v.st;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 busy after accept", {31'b0, req_ready}, 32'd0);
        while (!rsp_valid) @(negedge clk);
        // read trace
        check("R1 first read address", rd_log[rd0[5:0]], BASE + pri);
        nw0 = 0; nw1 = 0;
        for (int k = rd0; k < rd_n; k++) begin
            if (rd_log[k[5:0]][2]) begin
                nw1++;
                check("R3 word1 preceded by own word0", rd_log[(k-1) & 63], rd_log[k[5:0]] - 4);
            end else begin
                nw0++;
            end
        end
        check("R2 word0 reads", nw0, (v.kind == 2'd0) ? v.idx + 1 :
                                     (v.kind == 2'd1) ? 9 + v.idx : 16);
        check("R3 word1 reads", nw1, (v.kind == 2'd2) ? 0 : 1);
        if (v.kind != 2'd0)
            check("R5 secondary group address", rd_log[(rd0 + 8) & 63], BASE + sec);
        if (v.kind == 2'd2) begin
            check("R6 miss reported", {31'b0, rsp_hit}, 32'd0);
        end else begin
            check("R4 R7 hit", {31'b0, rsp_hit}, 32'd1);
            check("R2 R7 offset", rsp_offset, off);
            check("R7 word0", rsp_word0, tg | 32'h8000_0000 | ((v.kind == 2'd1) ? 32'h40 : 32'h0));
            check("R2 R7 word1", rsp_word1, w1);
            check("R7 real address", rsp_raddr, {w1[31:12], v.ea[11:0]});
            check("R10 write permission", {31'b0, rsp_wr_ok}, {31'b0, v.st | v.c});
        end
        rsp_ack = 1'b1; rsp_grant = v.gr;
        @(negedge clk);
        rsp_ack = 1'b0; rsp_grant = 1'b0;
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        wexp = 0;
        if (v.kind != 2'd2 && v.gr) begin
            if (!v.r) begin
                check("R8 referenced byte address", wa_log[(wr0 + wexp) & 63], BASE + off + 6);
                check("R8 referenced byte value", {24'b0, wd_log[(wr0 + wexp) & 63]},
                      {24'b0, w1[15:8] | 8'h01});
                wexp++;
            end
            if (!v.c && v.st) begin
                check("R9 changed byte address", wa_log[(wr0 + wexp) & 63], BASE + off + 7);
                check("R9 changed byte value", {24'b0, wd_log[(wr0 + wexp) & 63]},
                      {24'b0, w1[7:0] | 8'h80});
                wexp++;
            end
        end
        check("R8 R9 R11 write count", wr_n - wr0, wexp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset ready", {31'b0, req_ready}, 32'd1);
        check("R12 reset no response", {31'b0, rsp_valid}, 32'd0);
        check("R12 reset no memory request", {31'b0, mem_req}, 32'd0);
        rst_n = 1'b1;
        for (int n = 0; n < 8; n++) run(TBL[n], MASK);
        // directed: narrow table mask changes both group addresses (R1, R5)
        run('{24'h0A0B0C, 32'h0123_4567, 2'd1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1}, 32'h0000_01C0);
        // directed: deny on a hit needing both write-backs (R11)
        run('{24'h777777, 32'h6543_2100, 2'd0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0}, MASK);
        // directed: request held while busy is ignored until idle (R12)
        @(negedge clk);
        req_valid = 1'b1; req_vsid = 24'h1; req_ea = 32'h0; req_store = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        @(negedge clk);
        repeat (3) @(negedge clk);
        check("R12 ready low while walking", {31'b0, req_ready}, 32'd0);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        check("R6 empty table misses", {31'b0, rsp_hit}, 32'd0);
        rsp_ack = 1'b1; rsp_grant = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0; rsp_grant = 1'b0;
        check("R11 miss returns to idle", {31'b0, req_ready}, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end
endmodule